// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit decides where a processor fetches next after a control-transfer instruction. From the current program counter, one register operand and an offset or target value, it evaluates a signed test of the operand against zero and chooses between the sequential address, a PC-relative target, an absolute target and a return target of register plus immediate. For the same instruction it also produces the link value and its write enable, the delay-slot indication, and the strobes that set or clear two processor status bits: interrupt enable and a break-active flag.

All next-PC, taken, link and delay outputs are combinational in the instruction inputs. The two status bits sit in a small register inside the unit. That register changes at the clock edge on which a valid break or return instruction is presented. Instruction fetch, the pipeline and the register file are outside the unit. The unit takes its operands already read and hands back the link value for the pipeline to write.

Top module: `branch_nextpc_unit`

## Requirements
- R1: After synchronous reset, `irq_en_o` and `in_brk_o` are both 0.
- R2: With `kind_i` = 0 (conditional), `cond_i` selects a signed test of `opnd_i` against zero: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal. Codes 6 and 7 are never taken.
- R3: When the branch is not taken, `next_pc_o` equals `pc_i` + 4, modulo 2^32.
- R4: When a conditional or unconditional branch is taken, `next_pc_o` equals `pc_i` + offset if `abs_i` = 0, and equals the offset itself if `abs_i` = 1. The offset is `imm_i` when `use_imm_i` = 1 and `reg_b_i` otherwise.
- R5: `link_we_o` is 1, with `link_val_o` = `pc_i`, only for an unconditional branch (`kind_i` = 1) with `link_i` = 1 and for a break (`kind_i` = 2). `link_i` has no effect for conditional and return kinds.
- R6: `delay_slot_o` follows `delay_i` for conditional and unconditional kinds, whether or not the branch is taken. It is 0 for a break and 1 for a return.
- R7: A break (`kind_i` = 2) is always taken to the absolute offset, ignoring `abs_i`. It pulses `in_brk_set_o`, and `in_brk_o` is 1 after the clock edge.
- R8: A return (`kind_i` = 3) is taken to `opnd_i` + `imm_i`. With `ret_kind_i` = 1 it pulses `irq_en_set_o` and sets `irq_en_o`. With `ret_kind_i` = 2 it pulses `in_brk_clr_o` and clears `in_brk_o`. Values 0 and 3 leave both status bits unchanged.
- R9: While `valid_i` = 0, the unit reports not taken, no link write and no status strobe, and both status bits hold their values.
- R10: An unconditional branch (`kind_i` = 1) is taken for any value of `opnd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | A control-transfer instruction is presented |
| kind_i | input | 2 | 0 conditional, 1 unconditional, 2 break, 3 return |
| cond_i | input | 3 | Condition code for the conditional kind |
| ret_kind_i | input | 2 | Return variant: 0 plain, 1 interrupt, 2 break, 3 plain |
| abs_i | input | 1 | Target is absolute rather than PC-relative |
| link_i | input | 1 | Write the current PC to the destination register |
| delay_i | input | 1 | Instruction has a delay slot |
| use_imm_i | input | 1 | Offset comes from the immediate instead of the register |
| pc_i | input | 32 | Current program counter |
| opnd_i | input | 32 | Register tested against zero; base for returns |
| reg_b_i | input | 32 | Register offset or target |
| imm_i | input | 32 | Sign-extended immediate |
| next_pc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Branch is taken |
| link_we_o | output | 1 | Link register write enable |
| link_val_o | output | 32 | Value to write to the link register |
| delay_slot_o | output | 1 | The next instruction is a delay slot |
| irq_en_set_o | output | 1 | Strobe: set interrupt enable |
| in_brk_set_o | output | 1 | Strobe: set break-active |
| in_brk_clr_o | output | 1 | Strobe: clear break-active |
| irq_en_o | output | 1 | Interrupt enable status bit |
| in_brk_o | output | 1 | Break-active status bit |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath and a 4-byte sequential step. With a 32-bit datapath, the operands 0x80000000 and 0x7FFFFFFF lie at the signed extremes, which separates a signed comparison from an unsigned one. A PC of 0xFFFFFFFC reaches the wrap-around of the sequential step. A table sweeps every condition code over negative, zero and positive operands, with both relative and absolute targets and both offset sources. Directed sequences then take the status bits through break, the return variants and idle cycles.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    typedef enum logic [1:0] {
        KIND_COND  = 2'd0,
        KIND_JUMP  = 2'd1,
        KIND_BREAK = 2'd2,
        KIND_RET   = 2'd3
    } br_kind_e;

    typedef enum logic [2:0] {
        CC_EQ   = 3'd0,
        CC_NE   = 3'd1,
        CC_LT   = 3'd2,
        CC_LE   = 3'd3,
        CC_GT   = 3'd4,
        CC_GE   = 3'd5,
        CC_RSV6 = 3'd6,
        CC_RSV7 = 3'd7
    } cond_code_e;

    typedef enum logic [1:0] {
        RK_PLAIN = 2'd0,
        RK_IRQ   = 2'd1,
        RK_BRK   = 2'd2,
        RK_ALT   = 2'd3
    } ret_kind_e;

    typedef enum logic {
        TGT_OFFSET = 1'b0,
        TGT_RETURN = 1'b1
    } tgt_sel_e;

    // Status bit positions inside the status register
    localparam int ST_IRQ_EN = 0;
    localparam int ST_IN_BRK = 1;
    localparam int ST_BITS   = 2;

    typedef struct packed {
        logic     taken;
        logic     use_abs;
        tgt_sel_e tgt_sel;
        logic     link_we;
        logic     delay;
        logic     irq_en_set;
        logic     in_brk_set;
        logic     in_brk_clr;
    } br_ctrl_t;

    // Signed test of a value against zero, given its sign and zero flags
    function automatic logic cond_hit(input cond_code_e cc, input logic neg, input logic zero);
        logic r;
        case (cc)
            CC_EQ:   r = zero;
            CC_NE:   r = !zero;
            CC_LT:   r = neg;
            CC_LE:   r = neg || zero;
            CC_GT:   r = !neg && !zero;
            CC_GE:   r = !neg;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nxpc_cond_eval.sv
module nxpc_cond_eval
    import nxpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opnd_i,
    input  cond_code_e      cond_i,
    output logic            hit_o
);
    localparam int SIGN_BIT = XLEN - 1;

    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg  = opnd_i[SIGN_BIT];
        is_zero = (opnd_i == '0);
        hit_o   = cond_hit(cond_i, is_neg, is_zero);
    end

    always_comb begin
        if (cond_i == CC_RSV6 || cond_i == CC_RSV7) begin
            AST_RSV_NEVER_HIT: assert (!hit_o); // R2
        end
    end

endmodule

// File: rtl/nxpc_decode.sv
module nxpc_decode
    import nxpc_pkg::*;
(
    input  logic      valid_i,
    input  br_kind_e  kind_i,
    input  ret_kind_e ret_kind_i,
    input  logic      cond_hit_i,
    input  logic      abs_i,
    input  logic      link_i,
    input  logic      delay_i,
    output br_ctrl_t  ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        ctrl_o.tgt_sel = TGT_OFFSET;
        if (valid_i) begin
            case (kind_i)
                KIND_COND: begin
                    ctrl_o.taken   = cond_hit_i;
                    ctrl_o.use_abs = abs_i;
                    ctrl_o.delay   = delay_i;
                end
                KIND_JUMP: begin
                    ctrl_o.taken   = 1'b1;
                    ctrl_o.use_abs = abs_i;
                    ctrl_o.link_we = link_i;
                    ctrl_o.delay   = delay_i;
                end
                KIND_BREAK: begin
                    ctrl_o.taken      = 1'b1;
                    ctrl_o.use_abs    = 1'b1;
                    ctrl_o.link_we    = 1'b1;
                    ctrl_o.in_brk_set = 1'b1;
                end
                default: begin
                    ctrl_o.taken   = 1'b1;
                    ctrl_o.tgt_sel = TGT_RETURN;
                    ctrl_o.delay   = 1'b1;
                    ctrl_o.irq_en_set = (ret_kind_i == RK_IRQ);
                    ctrl_o.in_brk_clr = (ret_kind_i == RK_BRK);
                end
            endcase
        end
    end

    always_comb begin
        AST_ONE_BRK_STROBE: assert (!(ctrl_o.in_brk_set && ctrl_o.in_brk_clr)); // R7
        if (ctrl_o.link_we) begin
            AST_LINK_KINDS: assert (kind_i == KIND_JUMP || kind_i == KIND_BREAK); // R5
        end
    end

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
    import nxpc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] opnd_i,
    input  logic [XLEN-1:0] reg_b_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic            use_imm_i,
    input  br_ctrl_t        ctrl_i,
    output logic [XLEN-1:0] next_pc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] ret_pc;

    always_comb begin
        offset = use_imm_i ? imm_i : reg_b_i;
        seq_pc = pc_i + STEP;
        rel_pc = pc_i + offset;
        ret_pc = opnd_i + imm_i;
        if (!ctrl_i.taken) begin
            next_pc_o = seq_pc;
        end else if (ctrl_i.tgt_sel == TGT_RETURN) begin
            next_pc_o = ret_pc;
        end else if (ctrl_i.use_abs) begin
            next_pc_o = offset;
        end else begin
            next_pc_o = rel_pc;
        end
    end

endmodule

// File: rtl/nxpc_status.sv
module nxpc_status
    import nxpc_pkg::*;
#(
    parameter int NBITS = ST_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] set_i,
    input  logic [NBITS-1:0] clr_i,
    output logic [NBITS-1:0] q_o
);
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q_o[b] <= 1'b0;
            end else if (set_i[b]) begin
                q_o[b] <= 1'b1;
            end else if (clr_i[b]) begin
                q_o[b] <= 1'b0;
            end
        end

        AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
            set_i[b] |=> q_o[b]); // R7
        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (clr_i[b] && !set_i[b]) |=> !q_o[b]); // R8
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            (!set_i[b] && !clr_i[b]) |=> $stable(q_o[b])); // R9
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (q_o == '0)); // R1

endmodule

// File: rtl/branch_nextpc_unit.sv
module branch_nextpc_unit
    import nxpc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_i,
    input  logic [1:0]      kind_i,
    input  logic [2:0]      cond_i,
    input  logic [1:0]      ret_kind_i,
    input  logic            abs_i,
    input  logic            link_i,
    input  logic            delay_i,
    input  logic            use_imm_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] opnd_i,
    input  logic [XLEN-1:0] reg_b_i,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            taken_o,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_val_o,
    output logic            delay_slot_o,
    output logic            irq_en_set_o,
    output logic            in_brk_set_o,
    output logic            in_brk_clr_o,
    output logic            irq_en_o,
    output logic            in_brk_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    br_kind_e         kind;
    cond_code_e       cc;
    ret_kind_e        rk;
    logic             hit;
    br_ctrl_t         ctrl;
    logic [ST_BITS-1:0] st_set;
    logic [ST_BITS-1:0] st_clr;
    logic [ST_BITS-1:0] st_q;

    assign kind = br_kind_e'(kind_i);
    assign cc   = cond_code_e'(cond_i);
    assign rk   = ret_kind_e'(ret_kind_i);

    nxpc_cond_eval #(.XLEN(XLEN)) u_cond (
        .opnd_i (opnd_i),
        .cond_i (cc),
        .hit_o  (hit)
    );

    nxpc_decode u_dec (
        .valid_i    (valid_i),
        .kind_i     (kind),
        .ret_kind_i (rk),
        .cond_hit_i (hit),
        .abs_i      (abs_i),
        .link_i     (link_i),
        .delay_i    (delay_i),
        .ctrl_o     (ctrl)
    );

    nxpc_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .pc_i      (pc_i),
        .opnd_i    (opnd_i),
        .reg_b_i   (reg_b_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .ctrl_i    (ctrl),
        .next_pc_o (next_pc_o)
    );

    always_comb begin
        st_set = '0;
        st_clr = '0;
        st_set[ST_IRQ_EN] = ctrl.irq_en_set;
        st_set[ST_IN_BRK] = ctrl.in_brk_set;
        st_clr[ST_IN_BRK] = ctrl.in_brk_clr;
    end

    nxpc_status #(.NBITS(ST_BITS)) u_st (
        .clk   (clk),
        .rst   (rst),
        .set_i (st_set),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    assign taken_o      = ctrl.taken;
    assign link_we_o    = ctrl.link_we;
    assign link_val_o   = pc_i;
    assign delay_slot_o = ctrl.delay;
    assign irq_en_set_o = ctrl.irq_en_set;
    assign in_brk_set_o = ctrl.in_brk_set;
    assign in_brk_clr_o = ctrl.in_brk_clr;
    assign irq_en_o     = st_q[ST_IRQ_EN];
    assign in_brk_o     = st_q[ST_IN_BRK];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> (!taken_o && !link_we_o && !irq_en_set_o && !in_brk_set_o && !in_brk_clr_o)); // R9
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> (next_pc_o == pc_i + STEP)); // R3
    AST_LINK_PC: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (taken_o && link_val_o == pc_i)); // R5
    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 2'd1) |-> taken_o); // R10
    AST_EQ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 2'd0 && cond_i == 3'd0) |-> (taken_o == (opnd_i == '0))); // R2
    AST_BRK_ABS: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 2'd2) |->
            (!delay_slot_o && next_pc_o == (use_imm_i ? imm_i : reg_b_i))); // R7
    AST_RET_DELAY: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 2'd3) |-> (delay_slot_o && taken_o && next_pc_o == opnd_i + imm_i)); // R8
    AST_DELAY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !kind_i[1]) |-> (delay_slot_o == delay_i)); // R6

endmodule

// File: tb/sim_branch_nextpc_unit.sv
module sim_branch_nextpc_unit;

    localparam int XLEN = 32;
    localparam logic [31:0] PC0  = 32'h0000_1000;
    localparam logic [31:0] OFF0 = 32'h0000_0100;
    localparam int NV = 20;

    // {cond[2:0], operand[31:0], expected taken}
    localparam logic [35:0] VEC [NV] = '{
        {3'd0, 32'hFFFF_FFFB, 1'b0}, {3'd0, 32'h0000_0000, 1'b1}, {3'd0, 32'h0000_0007, 1'b0},
        {3'd1, 32'hFFFF_FFFB, 1'b1}, {3'd1, 32'h0000_0000, 1'b0}, {3'd1, 32'h0000_0007, 1'b1},
        {3'd2, 32'hFFFF_FFFB, 1'b1}, {3'd2, 32'h0000_0000, 1'b0}, {3'd2, 32'h0000_0007, 1'b0},
        {3'd3, 32'hFFFF_FFFB, 1'b1}, {3'd3, 32'h0000_0000, 1'b1}, {3'd3, 32'h0000_0007, 1'b0},
        {3'd4, 32'hFFFF_FFFB, 1'b0}, {3'd4, 32'h0000_0000, 1'b0}, {3'd4, 32'h0000_0007, 1'b1},
        {3'd5, 32'hFFFF_FFFB, 1'b0}, {3'd5, 32'h0000_0000, 1'b1}, {3'd5, 32'h0000_0007, 1'b1},
        {3'd4, 32'h8000_0000, 1'b0}, {3'd2, 32'h7FFF_FFFF, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid_i = 1'b0;
    logic [1:0] kind_i = '0;
    logic [2:0] cond_i = '0;
    logic [1:0] ret_kind_i = '0;
    logic abs_i = 1'b0, link_i = 1'b0, delay_i = 1'b0, use_imm_i = 1'b0;
    logic [31:0] pc_i = '0, opnd_i = '0, reg_b_i = '0, imm_i = '0;
    logic [31:0] next_pc_o, link_val_o;
    logic taken_o, link_we_o, delay_slot_o;
    logic irq_en_set_o, in_brk_set_o, in_brk_clr_o, irq_en_o, in_brk_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    branch_nextpc_unit #(.XLEN(XLEN), .INSN_BYTES(4)) u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .kind_i(kind_i), .cond_i(cond_i),
        .ret_kind_i(ret_kind_i), .abs_i(abs_i), .link_i(link_i), .delay_i(delay_i),
        .use_imm_i(use_imm_i), .pc_i(pc_i), .opnd_i(opnd_i), .reg_b_i(reg_b_i),
        .imm_i(imm_i), .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
        .link_val_o(link_val_o), .delay_slot_o(delay_slot_o), .irq_en_set_o(irq_en_set_o),
        .in_brk_set_o(in_brk_set_o), .in_brk_clr_o(in_brk_clr_o), .irq_en_o(irq_en_o),
        .in_brk_o(in_brk_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [2:0] c,
                         input logic [1:0] rk, input logic a, input logic l, input logic d,
                         input logic ui, input logic [31:0] pc, input logic [31:0] op,
                         input logic [31:0] rb, input logic [31:0] im);
        @(negedge clk);
        valid_i = v; kind_i = k; cond_i = c; ret_kind_i = rk; abs_i = a; link_i = l;
        delay_i = d; use_imm_i = ui; pc_i = pc; opnd_i = op; reg_b_i = rb; imm_i = im;
        #1;
    endtask

    task automatic idle_cycle();
        drive(1'b0, 2'd2, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_4000, 32'h0, 32'h0, 32'h0000_0040);
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 irq_en", {31'b0, irq_en_o}, 32'd0);
        chk("R1 in_brk", {31'b0, in_brk_o}, 32'd0);

        // Table sweep: conditional kind, relative (reg offset) and absolute (imm offset)
        for (int a = 0; a < 2; a++) begin
            for (int i = 0; i < NV; i++) begin
                logic [35:0] v;
                logic [31:0] exp_pc;
                v = VEC[i];
                drive(1'b1, 2'd0, v[35:33], 2'd0, a[0], 1'b1, i[0], a[0], PC0, v[32:1],
                      (a == 0) ? OFF0 : 32'hDEAD_0000, (a == 1) ? OFF0 : 32'h0000_BAD0);
                exp_pc = v[0] ? ((a == 1) ? OFF0 : PC0 + OFF0) : PC0 + 32'd4;
                chk("R2 taken", {31'b0, taken_o}, {31'b0, v[0]});
                chk(v[0] ? "R4 next_pc" : "R3 next_pc", next_pc_o, exp_pc);
                chk("R6 delay", {31'b0, delay_slot_o}, {31'b0, i[0]});
                chk("R5 link ignored", {31'b0, link_we_o}, 32'd0);
            end
        end
        // reserved condition codes
        drive(1'b1, 2'd0, 3'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, PC0, 32'h0, 32'h0, OFF0);
        chk("R2 code6", {31'b0, taken_o}, 32'd0);
        drive(1'b1, 2'd0, 3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, PC0, 32'h5, 32'h0, OFF0);
        chk("R2 code7", {31'b0, taken_o}, 32'd0);

        // R3 wrap of sequential step
        drive(1'b1, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFC, 32'h1, 32'h0, OFF0);
        chk("R3 wrap", next_pc_o, 32'h0000_0000);

        // R10/R4/R5 unconditional relative with register offset and link
        drive(1'b1, 2'd1, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_2000, 32'hFFFF_FFFF,
              32'hFFFF_FFF0, 32'h0000_0444);
        chk("R10 taken neg opnd", {31'b0, taken_o}, 32'd1);
        chk("R4 rel neg offset", next_pc_o, 32'h0000_1FF0);
        chk("R5 link_we", {31'b0, link_we_o}, 32'd1);
        chk("R5 link_val", link_val_o, 32'h0000_2000);
        chk("R6 jump delay", {31'b0, delay_slot_o}, 32'd1);
        // R10 unconditional absolute, no link
        drive(1'b1, 2'd1, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_2000, 32'h0, 32'h0, 32'h0000_0800);
        chk("R10 abs target", next_pc_o, 32'h0000_0800);
        chk("R5 no link", {31'b0, link_we_o}, 32'd0);

        // R7 break: abs_i ignored, link forced, no delay
        drive(1'b1, 2'd2, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_3000, 32'h0000_0009,
              32'h0, 32'h0000_0018);
        chk("R7 next_pc", next_pc_o, 32'h0000_0018);
        chk("R7 link_we", {31'b0, link_we_o}, 32'd1);
        chk("R7 link_val", link_val_o, 32'h0000_3000);
        chk("R6 break delay", {31'b0, delay_slot_o}, 32'd0);
        chk("R7 strobe", {31'b0, in_brk_set_o}, 32'd1);
        idle_cycle();
        chk("R7 in_brk set", {31'b0, in_brk_o}, 32'd1);
        // R9 idle: nothing taken, status held
        chk("R9 taken", {31'b0, taken_o}, 32'd0);
        chk("R9 next_pc", next_pc_o, 32'h0000_4004);
        chk("R9 strobes", {29'b0, irq_en_set_o, in_brk_set_o, in_brk_clr_o}, 32'd0);
        idle_cycle();
        chk("R9 in_brk held", {31'b0, in_brk_o}, 32'd1);

        // R8 plain return: no status change, link ignored
        drive(1'b1, 2'd3, 3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_5000, 32'h0000_7000,
              32'h1111_1111, 32'h0000_0008);
        chk("R8 ret target", next_pc_o, 32'h0000_7008);
        chk("R6 ret delay", {31'b0, delay_slot_o}, 32'd1);
        chk("R5 ret no link", {31'b0, link_we_o}, 32'd0);
        idle_cycle();
        chk("R8 plain keeps brk", {31'b0, in_brk_o}, 32'd1);
        chk("R8 plain keeps ie", {31'b0, irq_en_o}, 32'd0);

        // R8 break-return clears break-active
        drive(1'b1, 2'd3, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_5000, 32'h0000_6000,
              32'h0, 32'hFFFF_FFFC);
        chk("R8 brk-ret target", next_pc_o, 32'h0000_5FFC);
        chk("R8 clr strobe", {31'b0, in_brk_clr_o}, 32'd1);
        idle_cycle();
        chk("R8 in_brk cleared", {31'b0, in_brk_o}, 32'd0);

        // R8 interrupt return sets interrupt enable
        drive(1'b1, 2'd3, 3'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_5000, 32'h0000_0100,
              32'h0, 32'h0000_0010);
        chk("R8 ie strobe", {31'b0, irq_en_set_o}, 32'd1);
        idle_cycle();
        chk("R8 irq_en set", {31'b0, irq_en_o}, 32'd1);
        // R8 variant 3 behaves as plain
        drive(1'b1, 2'd3, 3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0000_0100, 32'h0, 32'h0);
        idle_cycle();
        chk("R8 variant3 ie", {31'b0, irq_en_o}, 32'd1);
        chk("R8 variant3 brk", {31'b0, in_brk_o}, 32'd0);

        // R1 reset again clears interrupt enable
        @(negedge clk);
        rst = 1'b1;
        valid_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset ie", {31'b0, irq_en_o}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule